// File: doc/BRIEF.md
# Handler return state controller

This block keeps track of the handler context a small processor core is running in and carries out its return instructions. The core can be in normal flow, in an exception handler, in a nested (double) exception handler, and independently in a hardware interrupt handler. On every entry into a handler the block copies the current privilege value into a shadow register reserved for that handler level. A hardware interrupt entry also masks further hardware interrupts.

Three special returns put the privilege value back from the matching shadow register and step the context back. They are the exception return, the double-exception return and the interrupt return. Two task-switch returns are only checked for legality. When legal, they hand a one-cycle request to an external task-switch unit. Every special return is held pending, with a busy output raised, until the core reports that no register writes are outstanding. Its legality is judged at that commit point, against the context as it stands then. An illegal return raises a one-cycle invalid-operation pulse and changes nothing. The plain return is not special. It pops the instruction pointer from the stack on the next cycle, never faults and does not wait for the write drain.

Top module: `hret_ctrl`

## Requirements
- R1: After reset, `busy`, `inv_op`, `priv_wr_en`, `task_ret`, `ip_pop`, `in_exc`, `in_dexc` and `in_hwi` are 0, and `irq_en` is 1.
- R2: An `ent_exc` pulse in normal context moves to exception context (`in_exc`=1) and saves `priv_cur` into the exception shadow. In exception context it moves to double-exception context (`in_dexc`=1, `in_exc`=0) and saves `priv_cur` into the double-exception shadow. In double-exception context it is ignored and no shadow is written.
- R3: An `ent_hwi` pulse while `in_hwi`=0 sets `in_hwi`, clears `irq_en` and saves `priv_cur` into the interrupt shadow. While `in_hwi`=1 it is ignored.
- R4: `op_code` values are 1 plain return, 2 exception return, 3 double-exception return, 4 interrupt return, 5 interrupt-task return and 6 task return. Codes 0 and 7 are ignored. A special return (2 to 6) presented with `op_valid` while `busy`=0 raises `busy` from the next cycle. Any operation presented while `busy`=1 is ignored.
- R5: A pending return commits at the first clock edge at which `pend_cnt` is 0 and neither entry pulse is high. Its result pulse (`priv_wr_en`, `task_ret` or `inv_op`) and any context change appear for one cycle after that edge, and `busy` falls at the same time.
- R6: An exception return committed in exception context (not double) writes the exception shadow on `priv_wr_data` with `priv_wr_en` and returns to normal context.
- R7: A double-exception return committed in double-exception context writes the double-exception shadow and returns to exception context.
- R8: An interrupt return committed while `in_hwi`=1 writes the interrupt shadow, clears `in_hwi` and sets `irq_en`.
- R9: A special return committed outside its matching context produces an `inv_op` pulse and no `priv_wr_en` or `task_ret`. The context flags, `irq_en` and the shadow contents are unchanged.
- R10: The interrupt-task return is legal when an exception, double-exception or interrupt context is active. The task return is legal when `is_orig_task`=1. A legal one gives a `task_ret` pulse with `task_kind` 1 for the interrupt-task return and 0 for the task return.
- R11: A plain return presented while `busy`=0 gives an `ip_pop` pulse one cycle later, with `ip_value` equal to `stack_top` at the accepting edge, whatever `pend_cnt` is. It never raises `inv_op`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_cur | input | PRIV_W | Current privilege register value |
| ent_exc | input | 1 | Exception entry pulse |
| ent_hwi | input | 1 | Hardware interrupt entry pulse |
| op_valid | input | 1 | Return instruction present |
| op_code | input | 3 | Return instruction code |
| is_orig_task | input | 1 | Current task is the original task |
| pend_cnt | input | CNT_W | Number of outstanding register writes |
| stack_top | input | IP_W | Value at top of stack |
| busy | output | 1 | Special return waiting for commit |
| inv_op | output | 1 | Invalid-operation exception pulse |
| priv_wr_en | output | 1 | Privilege register restore strobe |
| priv_wr_data | output | PRIV_W | Restored privilege value |
| task_ret | output | 1 | Request to the task-switch unit |
| task_kind | output | 1 | 1 interrupt-task return, 0 task return |
| ip_pop | output | 1 | Pop instruction pointer from stack |
| ip_value | output | IP_W | New instruction pointer |
| in_exc | output | 1 | In exception handler context |
| in_dexc | output | 1 | In double-exception handler context |
| in_hwi | output | 1 | In hardware interrupt handler context |
| irq_en | output | 1 | Hardware interrupts enabled |

## Verification
The hardest situation to reach is an entry pulse that lands while a return is already pending and the write counter has just drained. The commit must then slip by one cycle, and legality must be judged on the context the entry has created. The stimulus builds a double exception, issues a double-exception return with a nonzero write count, and drops the count to zero in the same cycle as an interrupt entry. A long pseudo-random phase then mixes entries, operations and write counts against the reference model.

// File: rtl/hret_pkg.sv
package hret_pkg;
   typedef enum logic [2:0] {
      OP_NONE  = 3'd0,
      OP_RET   = 3'd1,
      OP_ERET  = 3'd2,
      OP_DRET  = 3'd3,
      OP_HRET  = 3'd4,
      OP_ITRET = 3'd5,
      OP_TRET  = 3'd6,
      OP_RSVD  = 3'd7
   } ret_op_e;

   localparam int NUM_SHADOW = 3;
   localparam int SH_EXC     = 0;
   localparam int SH_DEXC    = 1;
   localparam int SH_HWI     = 2;

   localparam logic [1:0] LVL_NORM = 2'd0;
   localparam logic [1:0] LVL_EXC  = 2'd1;
   localparam logic [1:0] LVL_DEXC = 2'd2;
endpackage

// File: rtl/hret_ctx.sv
module hret_ctx
   import hret_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ent_exc,
   input  logic                  ent_hwi,
   input  logic                  do_eret,
   input  logic                  do_dret,
   input  logic                  do_hret,
   output logic [1:0]            lvl,
   output logic                  in_hwi,
   output logic                  irq_en,
   output logic [NUM_SHADOW-1:0] save
);
   logic [1:0] lvl_q;
   logic       hwi_q;
   logic       irq_q;

   always_comb begin
      save          = '0;
      save[SH_EXC]  = ent_exc && (lvl_q == LVL_NORM);
      save[SH_DEXC] = ent_exc && (lvl_q == LVL_EXC);
      save[SH_HWI]  = ent_hwi && !hwi_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= LVL_NORM;
         hwi_q <= 1'b0;
         irq_q <= 1'b1;
      end else begin
         if (ent_exc && (lvl_q != LVL_DEXC))
            lvl_q <= lvl_q + 2'd1;
         else if (do_eret)
            lvl_q <= LVL_NORM;
         else if (do_dret)
            lvl_q <= LVL_EXC;
         if (ent_hwi && !hwi_q) begin
            hwi_q <= 1'b1;
            irq_q <= 1'b0;
         end else if (do_hret) begin
            hwi_q <= 1'b0;
            irq_q <= 1'b1;
         end
      end
   end

   assign lvl    = lvl_q;
   assign in_hwi = hwi_q;
   assign irq_en = irq_q;
endmodule

// File: rtl/hret_shadow.sv
module hret_shadow #(
   parameter int PRIV_W = 8,
   parameter int NUM    = 3,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM-1:0]    save,
   input  logic [PRIV_W-1:0] priv_in,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [PRIV_W-1:0] rd_data
);
   logic [PRIV_W-1:0] sh_q [NUM];

   for (genvar gi = 0; gi < NUM; gi++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sh_q[gi] <= '0;
         else if (save[gi])
            sh_q[gi] <= priv_in;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM; k++)
         if (int'(rd_idx) == k) rd_data = sh_q[k];
   end
endmodule

// File: rtl/hret_seq.sv
module hret_seq
   import hret_pkg::*;
#(
   parameter int PRIV_W  = 8,
   parameter int CNT_W   = 4,
   parameter int IP_W    = 16,
   parameter bit POP_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_code,
   input  logic [CNT_W-1:0]  pend_cnt,
   input  logic              ent_any,
   input  logic [1:0]        lvl,
   input  logic              in_hwi,
   input  logic              is_orig_task,
   input  logic [PRIV_W-1:0] shadow_data,
   input  logic [IP_W-1:0]   stack_top,
   output logic [1:0]        shadow_idx,
   output logic              do_eret,
   output logic              do_dret,
   output logic              do_hret,
   output logic              busy,
   output logic              inv_op,
   output logic              priv_wr_en,
   output logic [PRIV_W-1:0] priv_wr_data,
   output logic              task_ret,
   output logic              task_kind,
   output logic              ip_pop,
   output logic [IP_W-1:0]   ip_value
);
   ret_op_e op_in;
   ret_op_e op_q;
   logic    pend_q;
   logic    commit;
   logic    legal;
   logic    accept;
   logic    special;

   assign op_in   = ret_op_e'(op_code);
   assign accept  = op_valid && !pend_q;
   assign special = (op_in == OP_ERET) || (op_in == OP_DRET) || (op_in == OP_HRET) ||
                    (op_in == OP_ITRET) || (op_in == OP_TRET);
   assign commit  = pend_q && (pend_cnt == '0) && !ent_any;

   always_comb begin
      unique case (op_q)
         OP_ERET:  legal = (lvl == LVL_EXC);
         OP_DRET:  legal = (lvl == LVL_DEXC);
         OP_HRET:  legal = in_hwi;
         OP_ITRET: legal = (lvl != LVL_NORM) || in_hwi;
         OP_TRET:  legal = is_orig_task;
         default:  legal = 1'b0;
      endcase
   end

   always_comb begin
      unique case (op_q)
         OP_ERET: shadow_idx = 2'(SH_EXC);
         OP_DRET: shadow_idx = 2'(SH_DEXC);
         default: shadow_idx = 2'(SH_HWI);
      endcase
   end

   assign do_eret = commit && legal && (op_q == OP_ERET);
   assign do_dret = commit && legal && (op_q == OP_DRET);
   assign do_hret = commit && legal && (op_q == OP_HRET);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q       <= 1'b0;
         op_q         <= OP_NONE;
         inv_op       <= 1'b0;
         priv_wr_en   <= 1'b0;
         priv_wr_data <= '0;
         task_ret     <= 1'b0;
         task_kind    <= 1'b0;
      end else begin
         inv_op     <= 1'b0;
         priv_wr_en <= 1'b0;
         task_ret   <= 1'b0;
         if (commit) begin
            pend_q <= 1'b0;
            if (!legal) begin
               inv_op <= 1'b1;
            end else if ((op_q == OP_ITRET) || (op_q == OP_TRET)) begin
               task_ret  <= 1'b1;
               task_kind <= (op_q == OP_ITRET);
            end else begin
               priv_wr_en   <= 1'b1;
               priv_wr_data <= shadow_data;
            end
         end else if (accept && special) begin
            pend_q <= 1'b1;
            op_q   <= op_in;
         end
      end
   end

   if (POP_REG) begin : g_pop_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ip_pop   <= 1'b0;
            ip_value <= '0;
         end else begin
            ip_pop <= accept && (op_in == OP_RET);
            if (accept && (op_in == OP_RET)) ip_value <= stack_top;
         end
      end
   end else begin : g_pop_comb
      assign ip_pop   = accept && (op_in == OP_RET);
      assign ip_value = stack_top;
   end

   assign busy = pend_q;
endmodule

// File: rtl/hret_ctrl.sv
module hret_ctrl
   import hret_pkg::*;
#(
   parameter int PRIV_W  = 8,
   parameter int CNT_W   = 4,
   parameter int IP_W    = 16,
   parameter bit POP_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PRIV_W-1:0] priv_cur,
   input  logic              ent_exc,
   input  logic              ent_hwi,
   input  logic              op_valid,
   input  logic [2:0]        op_code,
   input  logic              is_orig_task,
   input  logic [CNT_W-1:0]  pend_cnt,
   input  logic [IP_W-1:0]   stack_top,
   output logic              busy,
   output logic              inv_op,
   output logic              priv_wr_en,
   output logic [PRIV_W-1:0] priv_wr_data,
   output logic              task_ret,
   output logic              task_kind,
   output logic              ip_pop,
   output logic [IP_W-1:0]   ip_value,
   output logic              in_exc,
   output logic              in_dexc,
   output logic              in_hwi,
   output logic              irq_en
);
   if (PRIV_W < 1) begin : g_bad_priv
      $error("hret_ctrl: PRIV_W must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("hret_ctrl: CNT_W must be at least 1");
   end
   if (IP_W < 1) begin : g_bad_ip
      $error("hret_ctrl: IP_W must be at least 1");
   end

   logic [1:0]            lvl;
   logic [NUM_SHADOW-1:0] save;
   logic [1:0]            sh_idx;
   logic [PRIV_W-1:0]     sh_data;
   logic                  do_eret, do_dret, do_hret;
   logic                  hwi_s;

   hret_ctx u_ctx (
      .clk     (clk),
      .rst_n   (rst_n),
      .ent_exc (ent_exc),
      .ent_hwi (ent_hwi),
      .do_eret (do_eret),
      .do_dret (do_dret),
      .do_hret (do_hret),
      .lvl     (lvl),
      .in_hwi  (hwi_s),
      .irq_en  (irq_en),
      .save    (save)
   );

   hret_shadow #(.PRIV_W(PRIV_W), .NUM(NUM_SHADOW), .IDX_W(2)) u_shadow (
      .clk     (clk),
      .rst_n   (rst_n),
      .save    (save),
      .priv_in (priv_cur),
      .rd_idx  (sh_idx),
      .rd_data (sh_data)
   );

   hret_seq #(.PRIV_W(PRIV_W), .CNT_W(CNT_W), .IP_W(IP_W), .POP_REG(POP_REG)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .op_valid     (op_valid),
      .op_code      (op_code),
      .pend_cnt     (pend_cnt),
      .ent_any      (ent_exc || ent_hwi),
      .lvl          (lvl),
      .in_hwi       (hwi_s),
      .is_orig_task (is_orig_task),
      .shadow_data  (sh_data),
      .stack_top    (stack_top),
      .shadow_idx   (sh_idx),
      .do_eret      (do_eret),
      .do_dret      (do_dret),
      .do_hret      (do_hret),
      .busy         (busy),
      .inv_op       (inv_op),
      .priv_wr_en   (priv_wr_en),
      .priv_wr_data (priv_wr_data),
      .task_ret     (task_ret),
      .task_kind    (task_kind),
      .ip_pop       (ip_pop),
      .ip_value     (ip_value)
   );

   assign in_exc  = (lvl == LVL_EXC);
   assign in_dexc = (lvl == LVL_DEXC);
   assign in_hwi  = hwi_s;
endmodule

// File: rtl/hret_chk.sv
module hret_chk #(
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] pend_cnt,
   input logic             ent_exc,
   input logic             ent_hwi,
   input logic             busy,
   input logic             inv_op,
   input logic             priv_wr_en,
   input logic             task_ret,
   input logic             in_exc,
   input logic             in_dexc,
   input logic             in_hwi,
   input logic             irq_en
);
   p_hold_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (pend_cnt != '0)) |=> busy);

   p_no_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_cnt != '0) || ent_exc || ent_hwi) |=> (!priv_wr_en && !task_ret && !inv_op));

   p_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_wr_en || task_ret || inv_op) |-> $past(busy));

   p_one_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({inv_op, priv_wr_en, task_ret}));

   p_inv_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      inv_op |-> $stable({in_exc, in_dexc, in_hwi, irq_en}));

   p_irq_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_en) |-> (priv_wr_en && $fell(in_hwi)));

   p_ctx_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_exc && in_dexc));
endmodule

bind hret_ctrl hret_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pend_cnt   (pend_cnt),
   .ent_exc    (ent_exc),
   .ent_hwi    (ent_hwi),
   .busy       (busy),
   .inv_op     (inv_op),
   .priv_wr_en (priv_wr_en),
   .task_ret   (task_ret),
   .in_exc     (in_exc),
   .in_dexc    (in_dexc),
   .in_hwi     (in_hwi),
   .irq_en     (irq_en)
);

// File: tb/hret_ctrl_test.sv
module hret_ctrl_test;
   localparam int PW = 8;
   localparam int CW = 4;
   localparam int IW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [PW-1:0] priv_cur = '0;
   logic          ent_exc = 1'b0;
   logic          ent_hwi = 1'b0;
   logic          op_valid = 1'b0;
   logic [2:0]    op_code = 3'd0;
   logic          is_orig_task = 1'b0;
   logic [CW-1:0] pend_cnt = '0;
   logic [IW-1:0] stack_top = '0;
   logic          busy, inv_op, priv_wr_en, task_ret, task_kind, ip_pop;
   logic [PW-1:0] priv_wr_data;
   logic [IW-1:0] ip_value;
   logic          in_exc, in_dexc, in_hwi, irq_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit armed = 1'b0;

   always #10 clk = ~clk;

   hret_ctrl #(.PRIV_W(PW), .CNT_W(CW), .IP_W(IW)) uut (
      .clk(clk), .rst_n(rst_n), .priv_cur(priv_cur), .ent_exc(ent_exc), .ent_hwi(ent_hwi),
      .op_valid(op_valid), .op_code(op_code), .is_orig_task(is_orig_task),
      .pend_cnt(pend_cnt), .stack_top(stack_top), .busy(busy), .inv_op(inv_op),
      .priv_wr_en(priv_wr_en), .priv_wr_data(priv_wr_data), .task_ret(task_ret),
      .task_kind(task_kind), .ip_pop(ip_pop), .ip_value(ip_value), .in_exc(in_exc),
      .in_dexc(in_dexc), .in_hwi(in_hwi), .irq_en(irq_en)
   );

   // reference model state, advanced at each rising edge
   int          m_lvl = 0;
   bit          m_hwi = 0, m_irq = 1, m_pend = 0;
   int          m_op = 0;
   logic [PW-1:0] m_sh [3] = '{default: '0};
   bit          e_inv = 0, e_pwe = 0, e_tr = 0, e_tk = 0, e_pop = 0;
   logic [PW-1:0] e_pwd = '0;
   logic [IW-1:0] e_ipv = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_lvl = 0; m_hwi = 0; m_irq = 1; m_pend = 0; m_op = 0;
         e_inv = 0; e_pwe = 0; e_tr = 0; e_pop = 0;
         for (int k = 0; k < 3; k++) m_sh[k] = '0;
         armed = 1'b1;
      end else begin
         e_inv = 0; e_pwe = 0; e_tr = 0; e_pop = 0;
         if (m_pend && pend_cnt == 0 && !ent_exc && !ent_hwi) begin
            m_pend = 0;
            case (m_op)
               2: if (m_lvl == 1) begin e_pwe = 1; e_pwd = m_sh[0]; m_lvl = 0; end else e_inv = 1;
               3: if (m_lvl == 2) begin e_pwe = 1; e_pwd = m_sh[1]; m_lvl = 1; end else e_inv = 1;
               4: if (m_hwi) begin e_pwe = 1; e_pwd = m_sh[2]; m_hwi = 0; m_irq = 1; end else e_inv = 1;
               5: if (m_lvl != 0 || m_hwi) begin e_tr = 1; e_tk = 1; end else e_inv = 1;
               default: if (is_orig_task) begin e_tr = 1; e_tk = 0; end else e_inv = 1;
            endcase
         end else if (!m_pend && op_valid) begin
            if (op_code == 3'd1) begin e_pop = 1; e_ipv = stack_top; end
            else if (op_code >= 3'd2 && op_code <= 3'd6) begin m_pend = 1; m_op = int'(op_code); end
         end
         if (ent_exc) begin
            if (m_lvl == 0) begin m_sh[0] = priv_cur; m_lvl = 1; end
            else if (m_lvl == 1) begin m_sh[1] = priv_cur; m_lvl = 2; end
         end
         if (ent_hwi && !m_hwi) begin m_sh[2] = priv_cur; m_hwi = 1; m_irq = 0; end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare against the model on every falling edge
   always @(negedge clk) begin
      if (armed && rst_n && !done) begin
         check("R4 busy", 32'(busy), 32'(m_pend));
         check("R6 in_exc", 32'(in_exc), 32'(m_lvl == 1));
         check("R7 in_dexc", 32'(in_dexc), 32'(m_lvl == 2));
         check("R8 in_hwi", 32'(in_hwi), 32'(m_hwi));
         check("R3 irq_en", 32'(irq_en), 32'(m_irq));
         check("R9 inv_op", 32'(inv_op), 32'(e_inv));
         check("R5 priv_wr_en", 32'(priv_wr_en), 32'(e_pwe));
         if (e_pwe) check("R2 priv_wr_data", 32'(priv_wr_data), 32'(e_pwd));
         check("R10 task_ret", 32'(task_ret), 32'(e_tr));
         if (e_tr) check("R10 task_kind", 32'(task_kind), 32'(e_tk));
         check("R11 ip_pop", 32'(ip_pop), 32'(e_pop));
         if (e_pop) check("R11 ip_value", 32'(ip_value), 32'(e_ipv));
      end
   end

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic issue(input logic [2:0] code);
      op_valid = 1'b1; op_code = code; tick(); op_valid = 1'b0; op_code = 3'd0;
   endtask

   task automatic enter_exc(input logic [PW-1:0] p);
      priv_cur = p; ent_exc = 1'b1; tick(); ent_exc = 1'b0;
   endtask

   task automatic enter_hwi(input logic [PW-1:0] p);
      priv_cur = p; ent_hwi = 1'b1; tick(); ent_hwi = 1'b0;
   endtask

   initial begin
      tick(3);
      // R1 reset state
      check("R1 busy", 32'(busy), 0);
      check("R1 flags", 32'({in_exc, in_dexc, in_hwi}), 0);
      check("R1 irq_en", 32'(irq_en), 1);
      check("R1 pulses", 32'({inv_op, priv_wr_en, task_ret, ip_pop}), 0);
      rst_n = 1'b1;
      tick();

      // R11 plain return ignores pending writes
      pend_cnt = 4'd5; stack_top = 16'h1234;
      issue(3'd1); tick(2);
      pend_cnt = 4'd0;
      // R9 every special return illegal in normal context
      issue(3'd2); tick(2);
      issue(3'd3); tick(2);
      issue(3'd4); tick(2);
      issue(3'd5); tick(2);
      is_orig_task = 1'b0; issue(3'd6); tick(2);
      // R10 task return legal for original task
      is_orig_task = 1'b1; issue(3'd6); tick(2);
      // R4 reserved codes ignored
      issue(3'd0); issue(3'd7); tick(2);

      // R2 build a double exception; a third entry is ignored
      enter_exc(8'h11); enter_exc(8'h22); enter_exc(8'h33); tick();
      // R9 exception return illegal in double context, after drain
      pend_cnt = 4'd3; issue(3'd2); tick(3);
      issue(3'd1);                       // ignored while busy
      pend_cnt = 4'd0; tick(2);
      // R7 double return with drain landing on an interrupt entry
      pend_cnt = 4'd2; issue(3'd3); tick(2);
      pend_cnt = 4'd0; enter_hwi(8'h44); tick(3);
      // R10 interrupt-task return legal in exception context
      issue(3'd5); tick(2);
      // R8 interrupt return, then R6 exception return
      issue(3'd4); tick(2);
      issue(3'd2); tick(2);
      issue(3'd5); tick(2);
      enter_hwi(8'h55); enter_hwi(8'h66); issue(3'd5); tick(2);
      issue(3'd4); tick(2);

      // pseudo-random mix
      begin
         logic [31:0] lf = 32'h1ACE_5EED;
         for (int i = 0; i < 4000; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            op_valid     = lf[0] & lf[1];
            op_code      = lf[4:2];
            ent_exc      = (lf[7:5] == 3'd0);
            ent_hwi      = (lf[10:8] == 3'd0);
            pend_cnt     = lf[12] ? 4'(lf[15:13]) : 4'd0;
            is_orig_task = lf[16];
            priv_cur     = lf[23:16];
            stack_top    = lf[31:16];
            tick();
         end
      end
      op_valid = 0; ent_exc = 0; ent_hwi = 0; pend_cnt = 0;
      tick(4);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule